// File: doc/BRIEF.md
# I2C Bus Clock Waveform Generator

This block produces the SCL waveform for an I2C master from a fast peripheral clock. A single 32-bit configuration word sets the low-phase divisor, the high-phase divisor, a power-of-two prescale exponent and an SDA hold count. Each SCL phase lasts the divisor shifted left by the exponent, plus a fixed synthesis-time offset. With equal divisors the two phases are equally long, so the bus frequency is F_clk / (2 x (div x 2^exp + OFFSET)).

The master's control state machine drives `run`. When `run` is high, the generator starts with a high phase and then alternates levels. It emits a one-cycle tick at every level change. It also emits an SDA-update strobe a fixed hold time after every SCL falling edge. That hold time is the HOLD field plus three clock cycles. A configuration word written mid-phase is picked up only at the next level change. When `run` is low, SCL is released and every timer is cleared.

Field layout of `cfg_word`: bits 7:0 hold the low divisor, bits 15:8 the high divisor, bits 18:16 the exponent and bits 29:24 the HOLD field. All other bits are ignored.

Top module: `i2c_scl_wavegen`

## Requirements
- R1: While `run` is low, or `rst_n` is low, `scl_o` is 1 and `phase_tick` and `sda_strobe` are 0 from the next clock edge on. Dropping `run` mid-phase aborts the phase and cancels a pending strobe.
- R2: The first clock edge that samples `run` high starts a high phase of Lh cycles. `scl_o` goes low at the Lh-th edge after that start edge.
- R3: A phase lasts (div << exp) + OFFSET cycles, with OFFSET = 4 by default. The low phase takes its divisor from bits 7:0 and the high phase from bits 15:8. The exponent is in bits 18:16.
- R4: An exponent field larger than EXP_MAX (default 6) is treated as EXP_MAX.
- R5: `phase_tick` is a one-cycle pulse that is high in the first cycle of each new SCL level, and at no other time.
- R6: `sda_strobe` is a one-cycle pulse that comes HOLD + 3 cycles after the edge at which `scl_o` fell. HOLD is taken from bits 29:24.
- R7: A HOLD field larger than HOLD_MAX (default 40) is treated as HOLD_MAX.
- R8: The phase in progress keeps its length when `cfg_word` changes. The new word sets the length of the next phase, and the hold delay of the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Run/stop control from the master state machine |
| cfg_word | input | 32 | Divisors, exponent and hold field |
| scl_o | output | 1 | SCL level, 1 = released |
| phase_tick | output | 1 | One-cycle pulse at each SCL level change |
| sda_strobe | output | 1 | One-cycle pulse allowing SDA to change |

## Verification
Take the first edge that samples `run` high as edge 0. `scl_o` then falls at edge Lh and rises again at edge Lh+Ll. `phase_tick` is high in the cycle just after each of those two edges. `sda_strobe` is high in the cycle after edge Lh+HOLD+3. The bench drives inputs and samples outputs on falling clock edges, counting samples from the one that follows edge 0. It expects the first low sample at Lh+1, the rise Ll samples later and the strobe HOLD+3 samples after the fall. A mid-phase configuration change and a mid-phase stop are checked at the exact sample where each must, or must not, show.

// File: rtl/i2c_sclgen_pkg.sv
// Shared field layout and phase type for the SCL waveform generator.
// Assumes a 32-bit configuration word; positions are fixed here so that
// the decoder and any software-facing wrapper agree on them.
package i2c_sclgen_pkg;
    localparam int unsigned CFG_W    = 32;
    localparam int unsigned DIV_W    = 8;
    localparam int unsigned LO_LSB   = 0;
    localparam int unsigned HI_LSB   = 8;
    localparam int unsigned EXP_LSB  = 16;
    localparam int unsigned EXP_W    = 3;
    localparam int unsigned HOLD_LSB = 24;
    localparam int unsigned HOLD_W   = 6;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;
endpackage

// File: rtl/sclgen_cfg_decode.sv
// Combinational decoder: turns the live configuration word into two phase
// lengths (cycles) and a hold-counter preload.
// Assumes EXP_MAX < 2**EXP_W and OFFSET >= 1, so that every length is >= 1.
module sclgen_cfg_decode
    import i2c_sclgen_pkg::*;
#(
    parameter int unsigned OFFSET   = 4,
    parameter int unsigned EXP_MAX  = 6,
    parameter int unsigned HOLD_MAX = 40,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned HCNT_W   = 7
) (
    input  logic [CFG_W-1:0]  cfg_word,
    output logic [CNT_W-1:0]  len_lo,
    output logic [CNT_W-1:0]  len_hi,
    output logic [HCNT_W-1:0] hold_load
);
    localparam int unsigned NDIV = 2;

    logic [EXP_W-1:0]  exp_raw;
    logic [EXP_W-1:0]  exp_c;
    logic [HOLD_W-1:0] hold_raw;
    logic [HOLD_W-1:0] hold_c;
    logic [CNT_W-1:0]  len_arr [NDIV];

    // Clamp the prescale exponent to its legal maximum.
    always_comb begin
        exp_raw = cfg_word[EXP_LSB +: EXP_W];
        exp_c   = (exp_raw > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_raw;
    end

    // One length calculator per divisor: index 0 = low phase, 1 = high phase.
    for (genvar g = 0; g < NDIV; g++) begin : g_len
        localparam int unsigned LSB = (g == 0) ? LO_LSB : HI_LSB;
        logic [DIV_W-1:0] div_g;
        always_comb begin
            div_g      = cfg_word[LSB +: DIV_W];
            len_arr[g] = (CNT_W'(div_g) << exp_c) + CNT_W'(OFFSET);
        end
    end

    assign len_lo = len_arr[0];
    assign len_hi = len_arr[1];

    // Saturate the hold field and add 2 so that the strobe lands HOLD+3 edges later.
    always_comb begin
        hold_raw  = cfg_word[HOLD_LSB +: HOLD_W];
        hold_c    = (hold_raw > HOLD_W'(HOLD_MAX)) ? HOLD_W'(HOLD_MAX) : hold_raw;
        hold_load = HCNT_W'(hold_c) + HCNT_W'(2);
    end
endmodule

// File: rtl/sclgen_phase_timer.sv
// Phase sequencer: counts down each SCL phase and flips the level at zero.
// A phase length is loaded only at a boundary (or at start), so changes to
// the lengths never shorten the phase in progress. Starts with a high phase.
module sclgen_phase_timer
    import i2c_sclgen_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] len_lo,
    input  logic [CNT_W-1:0] len_hi,
    output logic             scl_o,
    output logic             phase_tick,
    output logic             fall_now
);
    logic             active;
    phase_e           phase;
    logic [CNT_W-1:0] cnt;

    // Boundary that ends a high phase: the hold timer starts here.
    assign fall_now = active && run && (cnt == '0) && (phase == PH_HIGH);

    // Phase counter, level and tick; idle or reset releases SCL.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            active     <= 1'b0;
            phase      <= PH_HIGH;
            cnt        <= '0;
            scl_o      <= 1'b1;
            phase_tick <= 1'b0;
        end else if (!active) begin
            active     <= 1'b1;
            phase      <= PH_HIGH;
            cnt        <= len_hi - CNT_W'(1);
            scl_o      <= 1'b1;
            phase_tick <= 1'b0;
        end else if (cnt == '0) begin
            if (phase == PH_HIGH) begin
                phase <= PH_LOW;
                cnt   <= len_lo - CNT_W'(1);
                scl_o <= 1'b0;
            end else begin
                phase <= PH_HIGH;
                cnt   <= len_hi - CNT_W'(1);
                scl_o <= 1'b1;
            end
            phase_tick <= 1'b1;
        end else begin
            cnt        <= cnt - CNT_W'(1);
            phase_tick <= 1'b0;
        end
    end
endmodule

// File: rtl/sclgen_hold_delay.sv
// SDA hold timer: starts on each SCL falling boundary and pulses sda_strobe
// once the preloaded count has run out. A new fall restarts it.
module sclgen_hold_delay #(
    parameter int unsigned HCNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              fall_now,
    input  logic [HCNT_W-1:0] hold_load,
    output logic              sda_strobe
);
    logic              busy;
    logic [HCNT_W-1:0] hcnt;

    // Count down from the preload and fire a single-cycle strobe at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            busy       <= 1'b0;
            hcnt       <= '0;
            sda_strobe <= 1'b0;
        end else if (fall_now) begin
            busy       <= 1'b1;
            hcnt       <= hold_load;
            sda_strobe <= 1'b0;
        end else if (busy && (hcnt == '0)) begin
            busy       <= 1'b0;
            sda_strobe <= 1'b1;
        end else begin
            if (busy) hcnt <= hcnt - HCNT_W'(1);
            sda_strobe <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_scl_wavegen.sv
// Top of the SCL waveform generator: decoder, phase sequencer and hold timer.
// Assumes the master state machine owns run and only writes cfg_word values
// whose hold delay is shorter than the low phase.
module i2c_scl_wavegen
    import i2c_sclgen_pkg::*;
#(
    parameter int unsigned OFFSET   = 4,
    parameter int unsigned EXP_MAX  = 6,
    parameter int unsigned HOLD_MAX = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             scl_o,
    output logic             phase_tick,
    output logic             sda_strobe
);
    localparam int unsigned CNT_W  = DIV_W + EXP_MAX + $clog2(OFFSET + 1) + 1;
    localparam int unsigned HCNT_W = $clog2(HOLD_MAX + 3) + 1;

    logic [CNT_W-1:0]  len_lo;
    logic [CNT_W-1:0]  len_hi;
    logic [HCNT_W-1:0] hold_load;
    logic              fall_now;

    sclgen_cfg_decode #(
        .OFFSET(OFFSET), .EXP_MAX(EXP_MAX), .HOLD_MAX(HOLD_MAX),
        .CNT_W(CNT_W), .HCNT_W(HCNT_W)
    ) u_dec (
        .cfg_word(cfg_word), .len_lo(len_lo), .len_hi(len_hi), .hold_load(hold_load)
    );

    sclgen_phase_timer #(.CNT_W(CNT_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(run), .len_lo(len_lo), .len_hi(len_hi),
        .scl_o(scl_o), .phase_tick(phase_tick), .fall_now(fall_now)
    );

    sclgen_hold_delay #(.HCNT_W(HCNT_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .run(run), .fall_now(fall_now),
        .hold_load(hold_load), .sda_strobe(sda_strobe)
    );
endmodule

// File: rtl/i2c_scl_wavegen_chk.sv
// Port-level checker for the SCL waveform generator, bound to the top.
module i2c_scl_wavegen_chk #(
    parameter int unsigned OFFSET = 4
) (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic scl_o,
    input logic phase_tick,
    input logic sda_strobe
);
    logic [15:0] low_cnt;

    // Length of the current low stretch of SCL, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || scl_o) low_cnt <= '0;
        else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 16'd1;
    end

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (scl_o && !phase_tick && !sda_strobe));

    a_r5_tick_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        phase_tick |-> (scl_o != $past(scl_o)));

    a_r3_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_o) && $past(run)) |-> (low_cnt >= 16'(OFFSET)));

    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        sda_strobe |=> !sda_strobe);
endmodule

bind i2c_scl_wavegen i2c_scl_wavegen_chk #(.OFFSET(OFFSET)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .scl_o(scl_o),
    .phase_tick(phase_tick), .sda_strobe(sda_strobe)
);

// File: tb/sim_i2c_scl_wavegen.sv
`timescale 1ns/1ps
module sim_i2c_scl_wavegen;
    localparam real HALF = 2.5;   // 200 MHz
    localparam int  NVEC = 8;
    // {cfg[31:0], Lh[15:0], Ll[15:0], hold_delay[7:0]}, OFFSET = 4
    localparam logic [71:0] VEC [NVEC] = '{
        {32'h0000_0305, 16'd7,     16'd9,     8'd3},   // R3 plain, hi != lo
        {32'h0501_020A, 16'd8,     16'd24,    8'd8},   // R3 exp 1, R6 hold 5
        {32'h0203_0101, 16'd12,    16'd12,    8'd5},   // R3 exp 3
        {32'h0000_0000, 16'd4,     16'd4,     8'd3},   // R3 zero divisors
        {32'h0107_0102, 16'd68,    16'd132,   8'd4},   // R4 exp 7 -> 6
        {32'h3F02_1414, 16'd84,    16'd84,    8'd43},  // R7 hold 63 -> 40
        {32'h2800_0A3C, 16'd14,    16'd64,    8'd43},  // R7 hold exactly 40
        {32'h0006_FFFF, 16'd16324, 16'd16324, 8'd3}    // R3 max divisor
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        scl_o, phase_tick, sda_strobe;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #(HALF) clk = ~clk;

    i2c_scl_wavegen u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_word(cfg_word),
        .scl_o(scl_o), .phase_tick(phase_tick), .sda_strobe(sda_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_check(input string req);
        check(scl_o == 1'b1, {req, " scl released"}, int'(scl_o), 1);
        check(phase_tick == 1'b0 && sda_strobe == 1'b0, {req, " no pulses"},
              int'({phase_tick, sda_strobe}), 0);
    endtask

    // One full high+low period from an idle start; sample s follows edge s-1.
    task automatic run_case(input logic [31:0] cfg, input int lh, input int ll,
                            input int hd, input string tag);
        int fall_s = -1, rise_s = -1, str_s = -1, ticks = 0, strobes = 0;
        bit tick_f = 0, tick_r = 0;
        @(negedge clk);
        cfg_word = cfg;
        run = 1'b1;
        for (int s = 1; s <= 40000 && rise_s < 0; s++) begin
            @(negedge clk);
            if (phase_tick) ticks++;
            if (sda_strobe) begin
                strobes++;
                if (str_s < 0) str_s = s;
            end
            if (fall_s < 0 && !scl_o) begin
                fall_s = s;
                tick_f = phase_tick;
            end else if (fall_s > 0 && scl_o) begin
                rise_s = s;
                tick_r = phase_tick;
            end
        end
        check(fall_s == lh + 1, {tag, " R2 high phase then fall"}, fall_s, lh + 1);
        check(rise_s - fall_s == ll, {tag, " R3 low phase length"}, rise_s - fall_s, ll);
        check(str_s - fall_s == hd, {tag, " R6 hold delay"}, str_s - fall_s, hd);
        check(strobes == 1, {tag, " R6 single strobe"}, strobes, 1);
        check(tick_f && tick_r && ticks == 2, {tag, " R5 ticks at both edges"}, ticks, 2);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        idle_check({tag, " R1 after stop"});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        int fall_s, rise_s, fall2_s;
        // R1: reset dominates run
        cfg_word = 32'h0000_0305;
        run = 1'b1;
        repeat (4) @(negedge clk);
        idle_check("R1 in reset");
        run = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        idle_check("R1 idle after reset");

        // Table of vectors
        for (int i = 0; i < NVEC; i++) begin
            run_case(VEC[i][71:40], int'(VEC[i][39:24]), int'(VEC[i][23:8]),
                     int'(VEC[i][7:0]), $sformatf("vec%0d", i));
        end

        // R8: change word during the first high phase (A: Lh7/Ll9 -> B: Lh10/Ll6)
        @(negedge clk);
        cfg_word = 32'h0000_0305;
        run = 1'b1;
        fall_s = -1; rise_s = -1; fall2_s = -1;
        for (int s = 1; s <= 100 && fall2_s < 0; s++) begin
            @(negedge clk);
            if (fall_s < 0 && !scl_o) fall_s = s;
            else if (fall_s > 0 && rise_s < 0 && scl_o) rise_s = s;
            else if (rise_s > 0 && !scl_o) fall2_s = s;
            if (s == 3) cfg_word = 32'h0000_0602;
        end
        check(fall_s == 8, "R8 running phase keeps old length", fall_s, 8);
        check(rise_s - fall_s == 6, "R8 next low phase uses new word", rise_s - fall_s, 6);
        check(fall2_s - rise_s == 10, "R8 next high phase uses new word", fall2_s - rise_s, 10);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);

        // R1: stop in the middle of a low phase, before the pending strobe
        cfg_word = 32'h0000_0305;
        run = 1'b1;
        for (int s = 1; s <= 9; s++) @(negedge clk);
        check(scl_o == 1'b0, "R1 setup low phase reached", int'(scl_o), 0);
        run = 1'b0;
        @(negedge clk);
        idle_check("R1 abort mid-low");
        @(negedge clk);
        check(sda_strobe == 1'b0, "R1 pending strobe cancelled", int'(sda_strobe), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule